// File: doc/BRIEF.md
# Stochastic Pulse-Stream Neuron

This block computes one neuron of a feed-forward network using only single-bit stochastic streams. A value in the range 0 to 1 is the fraction of clock cycles in which its line is high. Each synapse receives an unsigned input stream and a signed weight. The weight arrives as a magnitude stream on one of two mutually exclusive lines: one line for excitatory weights and one for inhibitory weights. An AND gate with the input multiplies the input by the weight magnitude. This gives at most one excitatory term and one inhibitory term per synapse.

All excitatory terms are merged by a wide OR into an excitatory net, and all inhibitory terms into an inhibitory net. An OR of streams never overflows. Its probability of being high is one minus the product of the complements of the term probabilities, so the net saturates smoothly towards always-high. The neuron fires in a cycle only when the excitatory net is high and the inhibitory net is low. The firing probability is therefore P+ times (1 - P-), and this product acts as the squashing function. A bias synapse has its input tied permanently high, so its weight lines feed the two nets directly. The result is held in one output flop.

Top module: `spn_neuron`

## Requirements
- R1: In a cycle whose clock edge sees `rst_n` low, the output flop is cleared, so `fire` reads 0 in the following cycle.
- R2: `fire` equals, one clock after the inputs are applied, the excitatory net AND NOT the inhibitory net. If no term is active, `fire` is 0.
- R3: A synapse term is active only when its input bit is 1 and the matching weight line is 1. A high weight line whose input bit is 0 has no effect on `fire`.
- R4: The excitatory net is the OR of every excitatory term. Any single active excitatory term, with no inhibitory term active, makes `fire` 1 one cycle later.
- R5: Any single active inhibitory term forces `fire` to 0 one cycle later, even when every excitatory term is active.
- R6: The bias synapse behaves as a synapse whose input is always 1. `bias_exc` alone makes `fire` 1, and `bias_inh` alone vetoes firing.
- R7: For every synapse and for the bias, the excitatory and inhibitory weight lines are never 1 in the same cycle. This is a rule for the driver of the block.
- R8: With independent random streams, the measured firing rate over a long window matches P+ x (1 - P-) within 0.03, where P+ = 1 - prod(1 - p_in*p_w) over the excitatory synapses and P- is the same product over the inhibitory synapses.
- R9: With every excitatory term held active and no inhibitory term, `fire` is 1 in every cycle. The net saturates at always-high and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| syn_in | input | N_SYN | Unsigned input stream bit for each synapse |
| w_exc | input | N_SYN | Excitatory weight line for each synapse |
| w_inh | input | N_SYN | Inhibitory weight line for each synapse |
| bias_exc | input | 1 | Excitatory weight line of the bias synapse |
| bias_inh | input | 1 | Inhibitory weight line of the bias synapse |
| fire | output | 1 | Registered output stream bit |

## Verification
A table of single-cycle patterns separates the cases that the gating logic must tell apart:
- a weight line high with its input low, which must be ignored;
- a lone excitatory term;
- a lone inhibitory term set against a full set of excitatory terms;
- bias-only excitation and bias-only inhibition.

Directed runs cover reset in the middle of a firing stream and a long saturated stretch in which every cycle must fire.

Two long runs drive shift-register random streams with chosen probabilities:
- one with light inhibition;
- one with heavy inhibition.

In each, the measured rate is compared with the product formula. These runs show whether the nets combine by OR, rather than by a sum or by a single lane.

// File: rtl/spn_pkg.sv
// Package: shared types for the stochastic pulse-stream neuron.
// Assumes streams are one bit per clock, value = fraction of high cycles.
package spn_pkg;

    // Smallest and largest synapse count the neuron is sized for.
    localparam int SPN_MIN_SYN = 2;
    localparam int SPN_MAX_SYN = 16;

    // Weighted contribution of one synapse to the two nets.
    typedef struct packed {
        logic exc;
        logic inh;
    } spn_term_t;

endpackage

// File: rtl/spn_synapse.sv
// Module: one synapse. Multiplies an unsigned input stream by a signed
// weight magnitude stream, producing an excitatory and an inhibitory term.
// Assumes w_exc and w_inh are never high together.
module spn_synapse
    import spn_pkg::*;
(
    input  logic      in_bit,
    input  logic      w_exc,
    input  logic      w_inh,
    output spn_term_t term
);

    // Stochastic multiply: AND of independent streams.
    always_comb begin
        term.exc = in_bit & w_exc;
        term.inh = in_bit & w_inh;
    end

endmodule

// File: rtl/spn_or_net.sv
// Module: OR-sum of a vector of term streams into one net stream.
// Built as a generate chain so each lane is an explicit stage.
// Assumes WIDTH >= 1. The result saturates at always-high.
module spn_or_net #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] terms,
    output logic             net
);

    logic [WIDTH:0] chain;

    // Seed of the OR chain.
    assign chain[0] = 1'b0;

    for (genvar g = 0; g < WIDTH; g++) begin : g_or
        // Fold lane g into the running OR.
        assign chain[g+1] = chain[g] | terms[g];
    end

    // Net is high when any lane is high.
    assign net = chain[WIDTH];

endmodule

// File: rtl/spn_neuron.sv
// Module: stochastic pulse-stream neuron (top).
// N_SYN data synapses plus one bias synapse with its input tied to 1.
// Excitatory and inhibitory terms are OR-summed separately. The output
// fires when the excitatory net is high and the inhibitory net is low.
// One registered output flop; synchronous active-low reset.
module spn_neuron
    import spn_pkg::*;
#(
    parameter int N_SYN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SYN-1:0] syn_in,
    input  logic [N_SYN-1:0] w_exc,
    input  logic [N_SYN-1:0] w_inh,
    input  logic             bias_exc,
    input  logic             bias_inh,
    output logic             fire
);

    localparam int LANES = N_SYN + 1;   // data synapses plus bias lane
    localparam int BIAS  = N_SYN;       // index of the bias lane

    spn_term_t        terms [LANES];
    logic [LANES-1:0] exc_vec;
    logic [LANES-1:0] inh_vec;
    logic             exc_net;
    logic             inh_net;

    for (genvar s = 0; s < LANES; s++) begin : g_syn
        if (s == BIAS) begin : g_bias
            // Bias synapse: input held permanently at 1.
            spn_synapse u_syn (
                .in_bit (1'b1),
                .w_exc  (bias_exc),
                .w_inh  (bias_inh),
                .term   (terms[s])
            );
        end else begin : g_data
            // Data synapse s.
            spn_synapse u_syn (
                .in_bit (syn_in[s]),
                .w_exc  (w_exc[s]),
                .w_inh  (w_inh[s]),
                .term   (terms[s])
            );
        end
        // Split the term pair into the two net vectors.
        assign exc_vec[s] = terms[s].exc;
        assign inh_vec[s] = terms[s].inh;
    end

    spn_or_net #(.WIDTH(LANES)) u_exc_net (
        .terms (exc_vec),
        .net   (exc_net)
    );

    spn_or_net #(.WIDTH(LANES)) u_inh_net (
        .terms (inh_vec),
        .net   (inh_net)
    );

    // Output flop: fire on excitation without inhibition.
    always_ff @(posedge clk) begin
        if (!rst_n) fire <= 1'b0;
        else        fire <= exc_net & ~inh_net;
    end

    initial begin
        // Elaboration guard on the synapse count.
        assert (N_SYN >= SPN_MIN_SYN && N_SYN <= SPN_MAX_SYN)
            else $error("N_SYN out of range");
    end

endmodule

// File: rtl/spn_neuron_chk.sv
// Checker: port-level properties of spn_neuron, bound to every instance.
// Assumes synchronous active-low reset; seen_q marks one clean cycle.
module spn_neuron_chk #(
    parameter int N_SYN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SYN-1:0] syn_in,
    input logic [N_SYN-1:0] w_exc,
    input logic [N_SYN-1:0] w_inh,
    input logic             bias_exc,
    input logic             bias_inh,
    input logic             fire
);

    logic seen_q;
    logic any_exc;
    logic any_inh;

    // Tracks whether the previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // Port-level view of the two nets.
    assign any_exc = (|(syn_in & w_exc)) | bias_exc;
    assign any_inh = (|(syn_in & w_inh)) | bias_inh;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !fire); // R1
    AST_FIRE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> fire == $past(any_exc & ~any_inh)); // R2
    AST_EXC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(any_exc && !any_inh)) |-> fire); // R4
    AST_INH_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(any_inh)) |-> !fire); // R5
    AST_BIAS_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(bias_exc && !any_inh)) |-> fire); // R6
    AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_exc & w_inh) == '0) && !(bias_exc && bias_inh)); // R7

endmodule

bind spn_neuron spn_neuron_chk #(.N_SYN(N_SYN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .syn_in   (syn_in),
    .w_exc    (w_exc),
    .w_inh    (w_inh),
    .bias_exc (bias_exc),
    .bias_inh (bias_inh),
    .fire     (fire)
);

// File: tb/spn_neuron_test.sv
// Bench for spn_neuron: vector table, directed reset/saturation tests,
// and two long statistical runs with shift-register random streams.
module spn_neuron_test;

    localparam int N = 4;
    localparam int NV = 10;
    localparam int WIN = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] syn_in = '0;
    logic [N-1:0] w_exc = '0;
    logic [N-1:0] w_inh = '0;
    logic         bias_exc = 1'b0;
    logic         bias_inh = 1'b0;
    logic         fire;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] rng = 32'h1ACE_B00C;

    // Fields: [14:11] in, [10:7] exc, [6:3] inh, [2] bias_exc, [1] bias_inh, [0] expected
    localparam logic [14:0] VEC [NV] = '{
        {4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0},  // R2 idle
        {4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1},  // R4 lone term
        {4'b0000, 4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0},  // R3 input low
        {4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0},  // R3 weight low
        {4'b1000, 4'b1000, 4'b0000, 1'b0, 1'b0, 1'b1},  // R4 top lane
        {4'b1111, 4'b0111, 4'b1000, 1'b0, 1'b0, 1'b0},  // R5 veto
        {4'b0111, 4'b0111, 4'b1000, 1'b0, 1'b0, 1'b1},  // R3 inh gated off
        {4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1},  // R6 bias fires
        {4'b1111, 4'b1111, 4'b0000, 1'b0, 1'b1, 1'b0},  // R6 bias veto
        {4'b0011, 4'b0001, 4'b0010, 1'b0, 1'b0, 1'b0}   // R5 mixed
    };

    spn_neuron #(.N_SYN(N)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .syn_in   (syn_in),
        .w_exc    (w_exc),
        .w_inh    (w_inh),
        .bias_exc (bias_exc),
        .bias_inh (bias_inh),
        .fire     (fire)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Records one check and prints a FAIL line on a mismatch.
    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Xorshift shift-register generator producing an 8-bit draw.
    task automatic draw(output logic [7:0] b);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        b = rng[15:8];
    endtask

    // Stream bit with probability p/256.
    task automatic bit_p(input int p, output logic o);
        logic [7:0] b;
        draw(b);
        o = (int'(b) < p);
    endtask

    // Long run: lanes 0,1 excitatory, 2,3 inhibitory; returns the measured rate.
    task automatic stat_run(input int pin[N], input int pw[N], output real rate);
        int ones = 0;
        logic x;
        for (int t = 0; t < WIN + 1; t++) begin
            @(negedge clk);
            if (t > 0) ones += int'(fire);
            syn_in = '0; w_exc = '0; w_inh = '0;
            for (int s = 0; s < N; s++) begin
                bit_p(pin[s], x); syn_in[s] = x;
                bit_p(pw[s], x);
                if (s < 2) w_exc[s] = x; else w_inh[s] = x;
            end
        end
        @(negedge clk);
        syn_in = '0; w_exc = '0; w_inh = '0;
        rate = real'(ones) / real'(WIN);
    endtask

    // Analytic firing probability P+ * (1 - P-).
    function automatic real expect_rate(input int pin[N], input int pw[N]);
        real qe = 1.0, qi = 1.0;
        for (int s = 0; s < N; s++) begin
            real p = (real'(pin[s]) / 256.0) * (real'(pw[s]) / 256.0);
            if (s < 2) qe = qe * (1.0 - p); else qi = qi * (1.0 - p);
        end
        return (1.0 - qe) * qi;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        real r, e;
        int ones;
        int pa[N], wa[N], pb[N], wb[N];

        // Reset state.
        repeat (3) @(negedge clk);
        check("R1 reset state", int'(fire), 0);
        rst_n = 1'b1;

        // Vector table: drive at negedge, sample at the following negedge.
        for (int v = 0; v < NV; v++) begin
            syn_in   = VEC[v][14:11];
            w_exc    = VEC[v][10:7];
            w_inh    = VEC[v][6:3];
            bias_exc = VEC[v][2];
            bias_inh = VEC[v][1];
            @(negedge clk);
            check($sformatf("R2 vector %0d", v), int'(fire), int'(VEC[v][0]));
        end

        // R1: reset asserted while the inputs would fire.
        syn_in = 4'b1111; w_exc = 4'b1111; w_inh = '0; bias_exc = 0; bias_inh = 0;
        @(negedge clk);
        check("R1 pre-reset firing", int'(fire), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-stream", int'(fire), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resume after reset", int'(fire), 1);

        // R9: saturated excitation fires every cycle.
        ones = 0;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            ones += int'(fire);
        end
        check("R9 saturation count", ones, 50);
        syn_in = '0; w_exc = '0;
        @(negedge clk);
        check("R2 return to idle", int'(fire), 0);

        // R8: light inhibition.
        pa = '{200, 128, 64, 96};
        wa = '{180, 220, 100, 60};
        stat_run(pa, wa, r);
        e = expect_rate(pa, wa);
        check($sformatf("R8 light inh rate x1000 (exp %0d)", int'(e * 1000.0)),
              ((r - e) < 0.03 && (e - r) < 0.03) ? 1 : 0, 1);

        // R8: heavy inhibition.
        pb = '{160, 240, 230, 200};
        wb = '{250, 120, 200, 180};
        stat_run(pb, wb, r);
        e = expect_rate(pb, wb);
        check($sformatf("R8 heavy inh rate x1000 (exp %0d)", int'(e * 1000.0)),
              ((r - e) < 0.03 && (e - r) < 0.03) ? 1 : 0, 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule